// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits behind the serial-bus protocol engine of a byte-addressed non-volatile memory. It collects the data bytes of one write transaction into a one-row buffer. When the protocol engine reports a STOP that follows a data acknowledge, it then spends a self-timed programming interval before copying the collected bytes into the memory array. The array is modelled as a synchronous single-write, single-read RAM.

The protocol engine drives a load strobe carrying the start address, and a byte strobe carrying a data byte together with an inhibit flag, which mirrors the write-control pin. It pulses the commit strobe on a STOP. The block replies with a busy flag, which the engine uses to withhold every acknowledge while programming runs. Only the low column bits of the address advance between bytes, so a long burst wraps inside its row. A second read port lets the surrounding logic, or a bench, fetch array contents.

Top module: `eep_page_commit`

## Requirements
- R1: A load strobe while idle captures the row (address bits above PAGE_W) and the column (low PAGE_W bits), and marks every buffer slot empty.
- R2: A byte strobe while idle with inhibit low stores the byte in the slot at the current column and advances the column by one modulo 2^PAGE_W; the row is never changed by a byte. The byte lands at array address {row, column}.
- R3: When more than 2^PAGE_W bytes follow one load, the column wraps to 0 and a later byte replaces the earlier byte in the same slot; the last byte written to a slot wins.
- R4: A commit is accepted only if the most recent accepted strobe since the load was a non-inhibited data byte and at least one slot is filled; any other commit leaves the array unchanged and busy low.
- R5: A byte strobe with inhibit high stores nothing, does not advance the column, and disarms the commit until a later non-inhibited byte arrives.
- R6: Busy is low after reset, rises on the cycle after an accepted commit and stays high for exactly PROG_CYCLES + 2^PAGE_W cycles.
- R7: While busy is high, load, byte and commit strobes have no effect on the buffer, the row, the column or the array.
- R8: A programming cycle writes only filled slots; other bytes of the row keep their previous contents, and no array write happens outside busy.
- R9: At the end of a programming cycle all slots are empty and the commit is disarmed, so a repeated commit without new bytes is ignored.
- R10: The read port returns the array byte at rd_addr_i one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb_i | input | 1 | Load start address |
| ld_addr_i | input | ADDR_W | Start address of the write |
| byte_stb_i | input | 1 | Data byte present |
| byte_inh_i | input | 1 | Write inhibit for this byte |
| byte_data_i | input | DATA_W | Data byte |
| commit_i | input | 1 | STOP seen by the protocol engine |
| busy_o | output | 1 | Programming cycle in progress |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Array read data, one cycle latency |

## Verification
Full-row bursts show the column-to-address mapping, and short bursts at a mid-row column show that empty slots leave their neighbours untouched. Bursts longer than a row start near the row end; they separate a correct column wrap from a carry into the row or a first-byte-wins policy. Commits after a fresh load, an inhibited byte or a finished cycle tell a correct arming rule apart from one that only looks at filled slots. Strobes issued during busy, followed by an unloaded byte, expose any leakage into the row, column or buffer. Random bursts with random inhibits and starting columns then mix all of these.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/eep_slot_buffer.sv
module eep_slot_buffer #(
  parameter int PAGE_W = 6,
  parameter int ROW_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    busy,
  input  logic                    clr,
  input  logic                    ld,
  input  logic [ROW_W+PAGE_W-1:0] ld_addr,
  input  logic                    byte_stb,
  input  logic                    inhibit,
  input  logic [DATA_W-1:0]       byte_data,
  input  logic [PAGE_W-1:0]       rd_idx,
  output logic [ROW_W-1:0]        row,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_filled,
  output logic                    armed,
  output logic                    any_filled
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [ROW_W-1:0]  row_q;
  logic [PAGE_W-1:0] col_q;
  logic [SLOTS-1:0]  fill_q;
  logic              armed_q;
  logic              take_ld;
  logic              take_byte;
  logic [SLOTS-1:0][DATA_W-1:0] slot_w;

  assign take_ld   = ld && !busy;
  assign take_byte = byte_stb && !busy && !ld && !inhibit;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      col_q   <= '0;
      fill_q  <= '0;
      armed_q <= 1'b0;
    end else if (clr) begin
      fill_q  <= '0;
      armed_q <= 1'b0;
    end else if (take_ld) begin
      row_q   <= ld_addr[ROW_W+PAGE_W-1:PAGE_W];
      col_q   <= ld_addr[PAGE_W-1:0];
      fill_q  <= '0;
      armed_q <= 1'b0;
    end else if (byte_stb && !busy) begin
      if (inhibit) begin
        armed_q <= 1'b0;
      end else begin
        fill_q[col_q] <= 1'b1;
        col_q         <= col_q + 1'b1;
        armed_q       <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (take_byte && col_q == PAGE_W'(i)) slot_q <= byte_data;
    end
    assign slot_w[i] = slot_q;
  end

  assign row        = row_q;
  assign rd_data    = slot_w[rd_idx];
  assign rd_filled  = fill_q[rd_idx];
  assign armed      = armed_q;
  assign any_filled = |fill_q;

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr) |=> ($stable(fill_q) && $stable(row_q) && $stable(col_q))); // R7
  AST_INHIBIT_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && inhibit && !ld && !busy && !clr) |=> ($stable(fill_q) && $stable(col_q) && !armed_q)); // R5
  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (ld && !busy) |=> (fill_q == '0)); // R1
  AST_BYTE_KEEPS_ROW: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && !ld) |=> $stable(row_q)); // R2
endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq #(
  parameter int PAGE_W      = 6,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_ok,
  output logic              busy,
  output logic              write_phase,
  output logic [PAGE_W-1:0] idx,
  output logic              clr
);
  import eep_pkg::*;
  localparam int CNT_W = (PROG_CYCLES < 2) ? 1 : $clog2(PROG_CYCLES);
  localparam logic [PAGE_W-1:0] LAST = '1;

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] idx_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (commit_ok) begin
            state_q <= SEQ_WAIT;
            cnt_q   <= CNT_W'(PROG_CYCLES - 1);
            busy_q  <= 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (cnt_q == '0) begin
            state_q <= SEQ_WRITE;
            idx_q   <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_WRITE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) begin
            state_q <= SEQ_IDLE;
            busy_q  <= 1'b0;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy        = busy_q;
  assign write_phase = (state_q == SEQ_WRITE);
  assign idx         = idx_q;
  assign clr         = (state_q == SEQ_WRITE) && (idx_q == LAST);

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (commit_ok && !busy_q) |=> busy_q); // R6
  AST_BUSY_ENDS_WRITING: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(state_q) == SEQ_WRITE)); // R6
  AST_WRITE_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_WAIT && cnt_q == '0) |=> (idx_q == '0 && busy_q)); // R6
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/eep_page_commit.sv
module eep_page_commit #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_stb_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              byte_stb_i,
  input  logic              byte_inh_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              commit_i,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic              busy;
  logic              clr;
  logic              write_phase;
  logic [PAGE_W-1:0] idx;
  logic [ROW_W-1:0]  row;
  logic [DATA_W-1:0] slot_data;
  logic              slot_filled;
  logic              armed;
  logic              any_filled;
  logic              commit_ok;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;

  eep_slot_buffer #(.PAGE_W(PAGE_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .clr       (clr),
    .ld        (ld_stb_i),
    .ld_addr   (ld_addr_i),
    .byte_stb  (byte_stb_i),
    .inhibit   (byte_inh_i),
    .byte_data (byte_data_i),
    .rd_idx    (idx),
    .row       (row),
    .rd_data   (slot_data),
    .rd_filled (slot_filled),
    .armed     (armed),
    .any_filled(any_filled)
  );

  assign commit_ok = commit_i && !busy && armed && any_filled;

  eep_prog_seq #(.PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .commit_ok  (commit_ok),
    .busy       (busy),
    .write_phase(write_phase),
    .idx        (idx),
    .clr        (clr)
  );

  assign mem_we    = write_phase && slot_filled;
  assign mem_waddr = {row, idx};

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(slot_data),
    .raddr(rd_addr_i),
    .rdata(rd_data_o)
  );

  assign busy_o = busy;

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy_o); // R8
  AST_NO_COMMIT_UNARMED: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !busy_o && !armed) |=> !busy_o); // R4
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !busy_o); // R6
endmodule

// File: tb/tb_eep_page_commit.sv
module tb_eep_page_commit;
  localparam int AW = 11, PW = 6, DW = 8, PROG = 20;
  localparam int SLOTS = 1 << PW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_stb = 0, byte_stb = 0, byte_inh = 0, commit = 0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic busy_o;
  logic [DW-1:0] rd_data;

  eep_page_commit #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst(rst), .ld_stb_i(ld_stb), .ld_addr_i(ld_addr),
    .byte_stb_i(byte_stb), .byte_inh_i(byte_inh), .byte_data_i(byte_data),
    .commit_i(commit), .busy_o(busy_o), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, busy_cnt = 0;
  bit done = 0;
  logic [DW-1:0] shadow [DEPTH];
  bit            known  [DEPTH];
  int            m_row, m_col;
  logic [DW-1:0] m_buf [SLOTS];
  bit [SLOTS-1:0] m_fill;
  bit            m_armed;

  always @(negedge clk) if (busy_o) busy_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int a, input bit upd);
    @(negedge clk); ld_stb = 1; ld_addr = AW'(a);
    @(negedge clk); ld_stb = 0;
    if (upd) begin
      m_row = a >> PW; m_col = a % SLOTS; m_fill = '0; m_armed = 0;
    end
  endtask

  task automatic do_byte(input logic [DW-1:0] d, input bit inh, input bit upd);
    @(negedge clk); byte_stb = 1; byte_data = d; byte_inh = inh;
    @(negedge clk); byte_stb = 0; byte_inh = 0;
    if (upd) begin
      if (inh) m_armed = 0;
      else begin
        m_buf[m_col] = d; m_fill[m_col] = 1; m_col = (m_col + 1) % SLOTS; m_armed = 1;
      end
    end
  endtask

  task automatic do_commit(input string req, input bit meddle);
    bit acc;
    acc = m_armed && (m_fill != '0);
    @(negedge clk); busy_cnt = 0; commit = 1;
    @(negedge clk); commit = 0;
    chk(busy_o == acc, req, busy_o, acc);
    if (acc) begin
      if (meddle) begin
        do_load($urandom_range(0, DEPTH - 1), 0);
        do_byte(8'hEE, 0, 0);
        do_byte(8'hDD, 0, 0);
        @(negedge clk); commit = 1;
        @(negedge clk); commit = 0;
      end
      while (busy_o) @(negedge clk);
      chk(busy_cnt == PROG + SLOTS, "R6", busy_cnt, PROG + SLOTS);
      for (int i = 0; i < SLOTS; i++)
        if (m_fill[i]) begin
          shadow[m_row * SLOTS + i] = m_buf[i];
          known[m_row * SLOTS + i] = 1;
        end
      m_fill = '0; m_armed = 0;
    end else begin
      repeat (3) @(negedge clk);
      chk(busy_cnt == 0, req, busy_cnt, 0);
    end
  endtask

  task automatic verify_row(input int r, input string req);
    for (int i = 0; i < SLOTS; i++) begin
      int a;
      a = r * SLOTS + i;
      if (known[a]) begin
        @(negedge clk); rd_addr = AW'(a);
        @(negedge clk);
        chk(rd_data == shadow[a], req, rd_data, shadow[a]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    m_row = 0; m_col = 0; m_fill = '0; m_armed = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy_o == 0, "R6 reset", busy_o, 0);

    // R1 R2 R10: full row from column 0
    do_load(3 * SLOTS, 1);
    for (int i = 0; i < SLOTS; i++) do_byte(DW'(i * 7 + 1), 0, 1);
    do_commit("R2", 0);
    verify_row(3, "R2 R10");

    // R8: short burst mid-row keeps neighbours
    do_load(3 * SLOTS + 10, 1);
    for (int i = 0; i < 3; i++) do_byte(DW'(8'hA0 + i), 0, 1);
    do_commit("R8", 0);
    verify_row(3, "R8");

    // R3: wrap inside row 5, starting near its end
    do_load(5 * SLOTS + 60, 1);
    for (int i = 0; i < SLOTS + 6; i++) do_byte(DW'(i ^ 8'h5A), 0, 1);
    do_commit("R3", 0);
    verify_row(5, "R3");
    verify_row(6, "R3 next row untouched");

    // R4: reload empties, load alone, inhibited last byte
    do_load(7 * SLOTS, 1);
    do_byte(8'h11, 0, 1);
    do_load(7 * SLOTS + 4, 1);
    do_commit("R4 after reload", 0);
    do_commit("R4 empty", 0);
    do_load(3 * SLOTS + 20, 1);
    do_byte(8'h33, 0, 1);
    do_byte(8'h44, 1, 1);
    do_commit("R5 disarm", 0);
    verify_row(3, "R5 no write");
    do_byte(8'h55, 0, 1);
    do_commit("R5 rearm", 0);
    verify_row(3, "R5 column held");

    // R7: strobes during busy; R9 repeat commit
    do_load(9 * SLOTS + 30, 1);
    do_byte(8'h66, 0, 1);
    do_commit("R7", 1);
    do_commit("R9 repeat", 0);
    do_byte(8'h77, 0, 1);
    do_commit("R7 column kept", 0);
    verify_row(9, "R7");

    // random mix
    for (int n = 0; n < 14; n++) begin
      int r, c, len;
      r = $urandom_range(0, (DEPTH / SLOTS) - 1);
      c = $urandom_range(0, SLOTS - 1);
      len = $urandom_range(1, SLOTS + 16);
      do_load(r * SLOTS + c, 1);
      for (int k = 0; k < len; k++)
        do_byte(DW'($urandom), ($urandom_range(0, 9) == 0), 1);
      do_commit("R4 random", 0);
      verify_row(r, "R2 R3 R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule